// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of a parameterised width over several clock cycles. It keeps a partial-product accumulator, a shifting multiplier register and one extra history bit to the right of that register. A one-cycle start request captures both operands. Each following cycle looks at the multiplier's low bit together with the history bit and either adds the multiplicand, subtracts it, or leaves the accumulator alone. It then shifts the accumulator, multiplier and history bit one place right as a single arithmetic unit.

After as many iterations as the operand has bits, the full double-width signed product is available as the upper accumulator half followed by the multiplier register. A one-cycle done pulse marks that moment. The result stays on the output until the next accepted start. While an operation runs, the block ignores new start requests and changes on the operand inputs. The accumulator carries one guard bit above the operand width, so the most negative multiplicand cannot overflow it.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, busy and done are 0 and product is all zeros.
- R2: A start seen while busy is 0 is accepted at that clock edge, and busy reads 1 from the next cycle on.
- R3: done rises exactly WIDTH clock cycles after the accepting edge. It stays high for one cycle only, and busy falls in that same cycle.
- R4: While done is 1, product equals the signed product of the captured multiplicand and multiplier, written as a 2*WIDTH-bit two's-complement value with the upper half first. For example, at WIDTH=8, -9 times -13 gives 16'h0075.
- R5: The product is correct when either operand, or both, is the most negative value (for example, -128 times -128 gives 16'h4000 at WIDTH=8).
- R6: A start asserted while busy is 1 has no effect: the completion cycle and the product of the running operation are unchanged.
- R7: Changes on the multiplicand and multiplier inputs after the accepting edge do not affect the product of the running operation.
- R8: While the block is idle and start is 0, product holds its value from one cycle to the next.
- R9: busy and done are never 1 in the same cycle.
- R10: A zero operand on either side gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a multiplication; accepted only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured when start is accepted |
| multiplier | input | WIDTH | Signed multiplier, captured when start is accepted |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, accumulator half in the upper bits |

## Verification
The hardest case to reach is an iteration that subtracts a most-negative multiplicand. That result only fits because of the guard bit, and random operands almost never select that exact value. Directed calls therefore pair the most negative value with itself, with the most positive value and with small magnitudes. Interference during a run is also hard to reach, because it needs the operand inputs and start to toggle inside the busy window. Every other random operation rewrites both operands and pulses start on alternate cycles while busy, right up to the cycle before done.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOOTH_HOLD = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

  // Recoding of the pair {low multiplier bit, history bit}
  function automatic booth_op_e booth_decode(input logic q_low, input logic q_hist);
    booth_op_e op;
    unique case ({q_low, q_hist})
      2'b10:   op = BOOTH_SUB;
      2'b01:   op = BOOTH_ADD;
      default: op = BOOTH_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic iter_fire,
  output logic last_iter,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] seq_cnt;

  assign accept    = start && !busy;
  assign iter_fire = busy;
  assign last_iter = busy && (seq_cnt == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      seq_cnt <= '0;
    end else begin
      done <= last_iter;
      if (accept) begin
        busy    <= 1'b1;
        seq_cnt <= CNT_LOAD;
      end else if (busy) begin
        seq_cnt <= seq_cnt - CNT_ONE;
        if (last_iter) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      q_low,
  input  logic      q_hist,
  output booth_op_e op
);
  assign op = booth_decode(q_low, q_hist);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] operand,
  input  booth_op_e     op,
  output logic [AW-1:0] result
);
  function automatic logic [AW-1:0] add_plain(input logic [AW-1:0] x, input logic [AW-1:0] y);
    return x + y;
  endfunction

  function automatic logic [AW-1:0] sub_by_complement(input logic [AW-1:0] x, input logic [AW-1:0] y);
    return x + (~y) + AW'(1);
  endfunction

  always_comb begin
    unique case (op)
      BOOTH_ADD: result = add_plain(acc, operand);
      BOOTH_SUB: result = sub_by_complement(acc, operand);
      default:   result = acc;
    endcase
  end
endmodule

// File: rtl/booth_shifter.sv
module booth_shifter #(
  parameter int AW = 9,
  parameter int QW = 8
) (
  input  logic [AW-1:0] acc_in,
  input  logic [QW-1:0] q_in,
  output logic [AW-1:0] acc_out,
  output logic [QW-1:0] q_out,
  output logic          hist_out
);
  // Arithmetic right shift of the concatenation {acc, q, hist}
  assign acc_out  = {acc_in[AW-1], acc_in[AW-1:1]};
  assign q_out    = {acc_in[0], q_in[QW-1:1]};
  assign hist_out = q_in[0];
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int AW = WIDTH + 1;   // one guard bit above the operand

  logic             accept;
  logic             iter_fire;
  logic             last_iter;
  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] mq_q;
  logic             hist_q;
  logic [WIDTH-1:0] mcand_q;
  logic [AW-1:0]    mcand_ext;
  booth_op_e        step_op;
  logic [AW-1:0]    step_sum;
  logic [AW-1:0]    acc_nxt;
  logic [WIDTH-1:0] mq_nxt;
  logic             hist_nxt;

  booth_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .iter_fire (iter_fire),
    .last_iter (last_iter),
    .busy      (busy),
    .done      (done)
  );

  booth_recoder recoder_i (
    .q_low  (mq_q[0]),
    .q_hist (hist_q),
    .op     (step_op)
  );

  assign mcand_ext = {mcand_q[WIDTH-1], mcand_q};

  booth_addsub #(.AW(AW)) addsub_i (
    .acc     (acc_q),
    .operand (mcand_ext),
    .op      (step_op),
    .result  (step_sum)
  );

  booth_shifter #(.AW(AW), .QW(WIDTH)) shifter_i (
    .acc_in   (step_sum),
    .q_in     (mq_q),
    .acc_out  (acc_nxt),
    .q_out    (mq_nxt),
    .hist_out (hist_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      hist_q  <= 1'b0;
      mcand_q <= '0;
    end else if (accept) begin
      acc_q   <= '0;
      mq_q    <= multiplier;
      hist_q  <= 1'b0;
      mcand_q <= multiplicand;
    end else if (iter_fire) begin
      acc_q   <= acc_nxt;
      mq_q    <= mq_nxt;
      hist_q  <= hist_nxt;
    end
  end

  assign product = {acc_q[WIDTH-1:0], mq_q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product,
  input logic               accept,
  input logic               last_iter
);
  localparam int CW = $clog2(WIDTH + 2);

  logic [CW-1:0]             run_cyc;
  logic signed [WIDTH-1:0]   cap_a;
  logic signed [WIDTH-1:0]   cap_b;
  logic signed [2*WIDTH-1:0] exp_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cyc <= '0;
      cap_a   <= '0;
      cap_b   <= '0;
    end else if (start && !busy) begin
      run_cyc <= '0;
      cap_a   <= multiplicand;
      cap_b   <= multiplier;
    end else if (busy) begin
      run_cyc <= run_cyc + CW'(1);
    end
  end

  assign exp_prod = cap_a * cap_b;

  assert_reset_idle_R1: assert property (@(posedge clk) $rose(rst_n) |-> (!busy && !done));
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_cyc == CW'(WIDTH)));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_last_to_done_R3: assert property (@(posedge clk) disable iff (!rst_n) last_iter |=> (done && !busy));
  // covers R5 and R7 as well: operands are captured at acceptance only
  assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n) done |-> (product == exp_prod));
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n) (busy && !last_iter) |=> (busy && !accept));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(product));
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product),
  .accept       (accept),
  .last_iter    (last_iter)
);

// File: tb/booth_seq_mult_tb_top.sv
module booth_seq_mult_tb_top;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  booth_seq_mult #(.WIDTH(W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  // Reference: sign-extend both operands, multiply, keep 2W bits
  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] ea;
    logic [2*W-1:0] eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string req);
    logic [2*W-1:0] expv;
    logic [2*W-1:0] held;
    expv = ref_mul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", {63'd0, busy}, 64'd1);
    for (int i = 0; i < W; i++) begin
      chk(done === 1'b0, "R3", {63'd0, done}, 64'd0);
      if (poke) begin
        mcand  = W'($urandom);
        mplier = W'($urandom);
        start  = (i % 2 == 0);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1, "R3", {63'd0, done}, 64'd1);
    chk(busy === 1'b0, "R9", {63'd0, busy}, 64'd0);
    chk(product === expv, poke ? "R4/R6/R7" : req, 64'(product), 64'(expv));
    held = product;
    @(negedge clk);
    chk(done === 1'b0, "R3", {63'd0, done}, 64'd0);
    chk(product === held, "R8", 64'(product), 64'(held));
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", {62'd0, busy, done}, 64'd0);
    chk(product === '0, "R1", 64'(product), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1", {63'd0, busy}, 64'd0);

    run_op(8'hF7, 8'hF3, 1'b0, "R4");   // -9 * -13 = 117
    run_op(8'h80, 8'h80, 1'b0, "R5");
    run_op(8'h80, 8'h7F, 1'b0, "R5");
    run_op(8'h7F, 8'h80, 1'b0, "R5");
    run_op(8'h80, 8'h01, 1'b0, "R5");
    run_op(8'h80, 8'hFF, 1'b1, "R5");
    run_op(8'h00, 8'h9C, 1'b0, "R10");
    run_op(8'h5A, 8'h00, 1'b1, "R10");
    run_op(8'h7F, 8'h7F, 1'b0, "R4");
    run_op(8'hFF, 8'h01, 1'b1, "R4");

    // idle with start low: product must not move
    begin
      logic [2*W-1:0] held;
      held = product;
      mcand = 8'h33; mplier = 8'h44;
      repeat (4) @(negedge clk);
      chk(product === held, "R8", 64'(product), 64'(held));
    end

    for (int k = 0; k < 200; k++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      run_op(ra, rb, (k % 2) == 1, "R4");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule